// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit sits beside the command controller of a serial nonvolatile memory. It keeps the status bits that steer writing: the write-enable latch, the write-in-progress flag, a two-bit block-protect field and a bit that arms the hardware protect pin. From those bits and the level of the protect pin it raises two permit flags. One says whether a status write may go ahead. The other says whether an array write at the 14-bit address now on its input may go ahead.

The controller talks to the unit through single-cycle strobes. Two of them, `wren_arm_i` and `frame_end_i`, mark the end of an enable opcode and the deassertion of chip select. `extra_bit_i` marks any further serial bit in the same frame. The others are the disable opcode, a status write carrying its data byte, an array write carrying its address, and the end of the self-timed write cycle. A request for which the permit flag is high commits on that clock edge. A refused request leaves every bit unchanged. Nonvolatile retention is not modelled. The protect field and the arming bit come out of reset with parameter values.

Top module: `wr_guard_status`

## Requirements
- R1: After reset, `status_o` holds WIP=0, WEL=0, the protect field equal to `RST_BP` and the arming bit equal to `RST_WPEN`. With the default parameters it reads 8'h00.
- R2: While the write-enable latch is 0, `sr_wr_ok_o` and `arr_wr_ok_o` are both 0, whatever the arming bit and `wp_i` are.
- R3: While the latch is 1, `sr_wr_ok_o` is 1 exactly when the arming bit is 0 or `wp_i` is 1. If the arming bit is 1 and `wp_i` is 0, the status write is refused. A refused status write changes nothing, including the arming bit.
- R4: While the latch is 1, `arr_wr_ok_o` is 1 exactly when the address lies outside the protected region. Protect field 00 protects nothing. 01 protects 0x3000..0x3FFF. 10 protects 0x2000..0x3FFF. 11 protects the whole array.
- R5: A committed status write loads the protect field from data bits 3:2 and the arming bit from data bit 7. Data bits 0, 1, 4, 5 and 6 are ignored.
- R6: The latch is set on a `frame_end_i` pulse when `wren_arm_i` has pulsed in the same frame and no `extra_bit_i` pulse has come after it. An extra bit cancels the pending set.
- R7: The latch is cleared by `wrdi_i` and by any committed status or array write. It is not set by any write.
- R8: A committed write (status or array) sets WIP in the next cycle. WIP stays 1 until a `wr_done_i` pulse clears it. A refused request does not set WIP.
- R9: The status byte layout is bit 0 WIP, bit 1 WEL, bits 3:2 the protect field, bit 7 the arming bit. Bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Protect pin level (low asserts hardware protection when armed) |
| wren_arm_i | input | 1 | Pulse: enable opcode fully received |
| extra_bit_i | input | 1 | Pulse: another serial bit arrived in the current frame |
| frame_end_i | input | 1 | Pulse: chip select deasserted |
| wrdi_i | input | 1 | Pulse: disable opcode received |
| sr_wr_req_i | input | 1 | Pulse: status write request |
| sr_wr_data_i | input | 8 | Data byte of the status write |
| arr_wr_req_i | input | 1 | Pulse: array write request |
| arr_addr_i | input | ADDR_W | Address of the array write |
| wr_done_i | input | 1 | Pulse: self-timed write cycle finished |
| sr_wr_ok_o | output | 1 | Status write permitted now |
| arr_wr_ok_o | output | 1 | Array write at `arr_addr_i` permitted now |
| status_o | output | 8 | Status byte |

## Verification
The bench sweeps addresses right at the quarter and half boundaries (0x1FFF/0x2000 and 0x2FFF/0x3000) under every protect setting. A decoder with an off-by-one boundary would grant or refuse the wrong edge address. It drives an enable frame broken by an extra bit and expects the latch to stay clear; a unit that ignored the extra bit would enable writes after a malformed frame. With the arming bit set and `wp_i` low, it tries to clear the arming bit and expects the refusal to hold. A unit that checked only the latch would let software unlock itself. Status data carrying ones in the reserved bits must not show through, or the status byte would read garbage.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_e;

  localparam int unsigned SB_WIP  = 0;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_BP0  = 2;
  localparam int unsigned SB_BP1  = 3;
  localparam int unsigned SB_WPEN = 7;
endpackage

// File: rtl/wpu_wel_latch.sv
module wpu_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_arm_i,
  input  logic extra_bit_i,
  input  logic frame_end_i,
  input  logic wrdi_i,
  input  logic commit_i,
  output logic wel_o
);
  logic arm_q, wel_q, set_now;

  // set only when the frame closes right after the opcode
  assign set_now = frame_end_i & (arm_q | wren_arm_i) & ~extra_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
    end else if (extra_bit_i || frame_end_i) begin
      arm_q <= 1'b0;
    end else if (wren_arm_i) begin
      arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (wrdi_i || commit_i) begin
      wel_q <= 1'b0;
    end else if (set_now) begin
      wel_q <= 1'b1;
    end
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/wpu_blk_dec.sv
module wpu_blk_dec
  import wpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  bp_e               bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam logic [ADDR_W:0] DEPTH   = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF_LO = DEPTH >> 1;
  localparam logic [ADDR_W:0] QTR_LO  = DEPTH - (DEPTH >> 2);

  logic [ADDR_W:0] addr_ext;
  assign addr_ext = {1'b0, addr_i};

  always_comb begin
    unique case (bp_i)
      BP_NONE: locked_o = 1'b0;
      BP_QTR:  locked_o = (addr_ext >= QTR_LO);
      BP_HALF: locked_o = (addr_ext >= HALF_LO);
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpu_sr_regs.sv
module wpu_sr_regs
  import wpu_pkg::*;
#(
  parameter logic [1:0] RST_BP   = 2'b00,
  parameter logic       RST_WPEN = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_commit_i,
  input  logic [7:0] sr_data_i,
  input  logic       any_commit_i,
  input  logic       wr_done_i,
  output bp_e        bp_o,
  output logic       wpen_o,
  output logic       wip_o
);
  bp_e  bp_q;
  logic wpen_q, wip_q;
  logic [4:0] unused_rsvd;

  assign unused_rsvd = {sr_data_i[6:4], sr_data_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q   <= bp_e'(RST_BP);
      wpen_q <= RST_WPEN;
    end else if (sr_commit_i) begin
      bp_q   <= bp_e'(sr_data_i[SB_BP1:SB_BP0]);
      wpen_q <= sr_data_i[SB_WPEN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q <= 1'b0;
    end else if (any_commit_i) begin
      wip_q <= 1'b1;
    end else if (wr_done_i) begin
      wip_q <= 1'b0;
    end
  end

  assign bp_o   = bp_q;
  assign wpen_o = wpen_q;
  assign wip_o  = wip_q;
endmodule

// File: rtl/wr_guard_status.sv
module wr_guard_status
  import wpu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter logic [1:0]  RST_BP   = 2'b00,
  parameter logic        RST_WPEN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              wren_arm_i,
  input  logic              extra_bit_i,
  input  logic              frame_end_i,
  input  logic              wrdi_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              arr_wr_req_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              wr_done_i,
  output logic              sr_wr_ok_o,
  output logic              arr_wr_ok_o,
  output logic [7:0]        status_o
);
  logic wel, wpen, wip, blk_locked, hw_lock;
  logic sr_commit, arr_commit, any_commit;
  bp_e  bp;

  assign hw_lock     = wpen & ~wp_i;
  assign sr_wr_ok_o  = wel & ~hw_lock;
  assign arr_wr_ok_o = wel & ~blk_locked;
  assign sr_commit   = sr_wr_req_i & sr_wr_ok_o;
  assign arr_commit  = arr_wr_req_i & arr_wr_ok_o;
  assign any_commit  = sr_commit | arr_commit;

  wpu_wel_latch u_wel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wren_arm_i  (wren_arm_i),
    .extra_bit_i (extra_bit_i),
    .frame_end_i (frame_end_i),
    .wrdi_i      (wrdi_i),
    .commit_i    (any_commit),
    .wel_o       (wel)
  );

  wpu_sr_regs #(
    .RST_BP   (RST_BP),
    .RST_WPEN (RST_WPEN)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sr_commit_i  (sr_commit),
    .sr_data_i    (sr_wr_data_i),
    .any_commit_i (any_commit),
    .wr_done_i    (wr_done_i),
    .bp_o         (bp),
    .wpen_o       (wpen),
    .wip_o        (wip)
  );

  wpu_blk_dec #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .bp_i     (bp),
    .addr_i   (arr_addr_i),
    .locked_o (blk_locked)
  );

  always_comb begin
    status_o                  = 8'h00;
    status_o[SB_WIP]          = wip;
    status_o[SB_WEL]          = wel;
    status_o[SB_BP1:SB_BP0]   = bp;
    status_o[SB_WPEN]         = wpen;
  end
endmodule

// File: rtl/wpu_chk.sv
module wpu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_i,
  input logic       sr_wr_req_i,
  input logic       arr_wr_req_i,
  input logic       wr_done_i,
  input logic       sr_wr_ok_o,
  input logic       arr_wr_ok_o,
  input logic [7:0] status_o
);
  AST_NO_PERMIT_WO_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] |-> (!sr_wr_ok_o && !arr_wr_ok_o)); // R2

  AST_SR_HW_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !wp_i) |-> !sr_wr_ok_o); // R3

  AST_ALL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:2] == 2'b11) |-> !arr_wr_ok_o); // R4

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sr_wr_req_i && sr_wr_ok_o) |=> ($stable(status_o[7]) && $stable(status_o[3:2]))); // R5

  AST_WEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sr_wr_req_i && sr_wr_ok_o) || (arr_wr_req_i && arr_wr_ok_o)) |=> !status_o[1]); // R7

  AST_WIP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sr_wr_req_i && sr_wr_ok_o) || (arr_wr_req_i && arr_wr_ok_o)) |=> status_o[0]); // R8

  AST_WIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !wr_done_i) |=> status_o[0]); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000); // R9
endmodule

bind wr_guard_status wpu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wp_i         (wp_i),
  .sr_wr_req_i  (sr_wr_req_i),
  .arr_wr_req_i (arr_wr_req_i),
  .wr_done_i    (wr_done_i),
  .sr_wr_ok_o   (sr_wr_ok_o),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .status_o     (status_o)
);

// File: tb/wr_guard_status_tb.sv
module wr_guard_status_tb;
  localparam int unsigned AW = 14;

  logic clk_i = 1'b0, rst_ni = 1'b0, wp_i = 1'b1;
  logic wren_arm_i = 0, extra_bit_i = 0, frame_end_i = 0, wrdi_i = 0;
  logic sr_wr_req_i = 0, arr_wr_req_i = 0, wr_done_i = 0;
  logic [7:0] sr_wr_data_i = '0;
  logic [AW-1:0] arr_addr_i = '0;
  logic sr_wr_ok_o, arr_wr_ok_o;
  logic [7:0] status_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  // model
  bit m_wel, m_wip, m_wpen, m_arm;
  bit [1:0] m_bp;

  always #4 clk_i = ~clk_i;

  wr_guard_status u_dut (.*);

  function automatic bit locked_f(bit [1:0] bp, bit [AW-1:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a >= 14'h3000;
      2'd2: return a >= 14'h2000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] stat_f();
    return {m_wpen, 3'b000, m_bp, m_wel, m_wip};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // op: 0 idle 1 arm 2 extra 3 frame_end 4 wrdi 5 sr_wr 6 arr_wr 7 done
  task automatic step(int op, bit [7:0] d, bit [AW-1:0] a, bit wp, string req);
    bit sr_ok, ar_ok;
    wp_i = wp; sr_wr_data_i = d; arr_addr_i = a;
    wren_arm_i = (op == 1); extra_bit_i = (op == 2); frame_end_i = (op == 3);
    wrdi_i = (op == 4); sr_wr_req_i = (op == 5); arr_wr_req_i = (op == 6);
    wr_done_i = (op == 7);
    #1;
    sr_ok = m_wel && (!m_wpen || wp);
    ar_ok = m_wel && !locked_f(m_bp, a);
    chk({req, " R2/R3 sr_ok"}, {7'd0, sr_wr_ok_o}, {7'd0, sr_ok});
    chk({req, " R2/R4 arr_ok"}, {7'd0, arr_wr_ok_o}, {7'd0, ar_ok});
    case (op)
      1: m_arm = 1;
      2: m_arm = 0;
      3: begin if (m_arm) m_wel = 1; m_arm = 0; end
      4: m_wel = 0;
      5: if (sr_ok) begin m_bp = d[3:2]; m_wpen = d[7]; m_wip = 1; m_wel = 0; end
      6: if (ar_ok) begin m_wip = 1; m_wel = 0; end
      7: m_wip = 0;
      default: ;
    endcase
    @(negedge clk_i);
    wren_arm_i = 0; extra_bit_i = 0; frame_end_i = 0; wrdi_i = 0;
    sr_wr_req_i = 0; arr_wr_req_i = 0; wr_done_i = 0;
    chk({req, " R9 status"}, status_o, stat_f());
  endtask

  task automatic enable(bit wp);
    step(1, 8'h00, '0, wp, "R6 arm");
    step(3, 8'h00, '0, wp, "R6 close");
  endtask

  initial begin
    void'($urandom(32'd4711));
    #21 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset status", status_o, 8'h00);

    step(5, 8'h8C, '0, 1, "R2 sr without wel");
    step(6, 8'h00, 14'h0000, 1, "R2 arr without wel");
    // broken enable frame
    step(1, 8'h00, '0, 1, "R6 arm");
    step(2, 8'h00, '0, 1, "R6 extra bit");
    step(3, 8'h00, '0, 1, "R6 cancelled close");
    chk("R6 wel stays clear", {7'd0, status_o[1]}, 8'h00);
    enable(1);
    chk("R6 wel set", {7'd0, status_o[1]}, 8'h01);
    step(4, 8'h00, '0, 1, "R7 wrdi");
    // quarter protect, junk in reserved bits
    enable(1);
    step(5, 8'h77, '0, 1, "R5 sr junk bits");
    chk("R5 bp loaded, wpen 0", status_o & 8'h8C, 8'h04);
    step(7, 8'h00, '0, 1, "R8 done");
    foreach (m_bp[i]) ;
    for (int bp = 0; bp < 4; bp++) begin
      enable(1);
      step(5, 8'(bp << 2), '0, 1, "R5 set bp");
      step(7, 8'h00, '0, 1, "R8 done");
      enable(1);
      step(0, 8'h00, 14'h1FFF, 1, "R4 edge 1FFF");
      step(0, 8'h00, 14'h2000, 1, "R4 edge 2000");
      step(0, 8'h00, 14'h2FFF, 1, "R4 edge 2FFF");
      step(0, 8'h00, 14'h3000, 1, "R4 edge 3000");
      step(0, 8'h00, 14'h3FFF, 1, "R4 edge 3FFF");
      step(6, 8'h00, 14'h0000, 1, "R4 write low");
      step(7, 8'h00, '0, 1, "R8 done");
    end
    // arm wpen, then try to clear it with wp low
    enable(1);
    step(5, 8'h88, '0, 1, "R5 set wpen");
    step(7, 8'h00, '0, 1, "R8 done");
    enable(0);
    step(5, 8'h00, '0, 0, "R3 locked sr write");
    chk("R3 wpen kept", status_o & 8'h8C, 8'h88);
    step(6, 8'h00, 14'h1000, 0, "R3 array still writable");
    chk("R8 wip set", {7'd0, status_o[0]}, 8'h01);
    step(0, 8'h00, '0, 0, "R8 wip held");
    step(7, 8'h00, '0, 0, "R8 done");

    // random
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op >= 8) begin
        op = (op == 8) ? 1 : 3;
      end
      step(op, 8'($urandom), AW'($urandom), bit'($urandom_range(0, 1)), "RND");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule